// File: doc/BRIEF.md
# Dual-Mode Branch Linkage Unit

This block resolves subroutine calls and returns for a processor core that runs in either a narrow 24-bit or a wide 31-bit addressing mode. The caller hands it an operation code, the current addressing mode, the branch target register word, the present contents of the link register, the address of the next sequential instruction, and the status fields (instruction length code, condition code, program mask). One clock later the block returns the next fetch address, the addressing mode that applies after the branch, and a linkage word with a write enable and register index for the register file.

The addressing mode is carried in the most significant bit of a 32-bit address word. A set bit selects the wide mode, where the 31 bits below it form the address. A clear bit selects the narrow mode, where only the low 24 bits count. The two mode-setting operations take the new mode from that bit of the target word. They also record the caller's mode in the same bit of the link word, so a call followed by a return through the saved word lands back in the caller's mode. This holds for all four pairings of caller and callee width.

Top module: `branch_link_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_wr_en, out_mode, out_wr_idx, out_target and out_link are all zero.
- R2: Results appear exactly one clock after the request. out_valid equals in_valid of the previous cycle, and out_wr_en is never high while out_valid is low.
- R3: The next fetch address is the target word masked to the mode in force after the branch. Narrow mode (mode 0) keeps bits 23:0 and clears bits 31:24. Wide mode (mode 1) keeps bits 30:0 and clears bit 31.
- R4: Operation 0 (legacy link) leaves the mode unchanged. In narrow mode its link word holds the instruction length code in bits 31:30, the condition code in 29:28, the program mask in 27:24 and next-address bits 23:0. In wide mode it holds 1 in bit 31 and next-address bits 30:0.
- R5: Operation 1 (save) leaves the mode unchanged. Its link word holds next-address bits 23:0 with bits 31:24 zero in narrow mode, and 1 in bit 31 with next-address bits 30:0 in wide mode.
- R6: Operation 2 (save and set mode) takes the new mode from bit 31 of the target word. Its link word holds the caller's mode in bit 31 and, below it, the next address masked to the caller's mode.
- R7: Operation 3 (set mode) takes the new mode from bit 31 of the target word. With a nonzero link index it writes the link register's old bits 30:0 with the caller's mode in bit 31. With link index 0 it writes nothing.
- R8: Operations 0, 1 and 2 always assert out_wr_en, and out_wr_idx carries the requested link index for every operation.
- R9: A save-and-set-mode call followed by a set-mode return through the saved link word restores the caller's mode and its masked return address, in all four narrow/wide pairings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Operation: 0 legacy link, 1 save, 2 save and set mode, 3 set mode |
| in_cur_mode | input | 1 | Current addressing mode, 1 = wide 31-bit |
| in_target | input | 32 | Target register word, bit 31 is the mode flag |
| in_link_val | input | 32 | Present contents of the link register |
| in_link_idx | input | 4 | Link register index, 0 = none for set mode |
| in_next_addr | input | 32 | Address of the next sequential instruction |
| in_ilc | input | 2 | Instruction length code in halfwords |
| in_cc | input | 2 | Condition code |
| in_pmask | input | 4 | Program mask |
| out_valid | output | 1 | Result present this cycle |
| out_target | output | 32 | Next fetch address |
| out_mode | output | 1 | Mode after the branch |
| out_wr_en | output | 1 | Write the link word to the register file |
| out_wr_idx | output | 4 | Register index for the write |
| out_link | output | 32 | Linkage word |

## Verification
Each operation is run from both starting modes against target words with the mode bit set and clear. Each run also sets the upper junk bits, which tells apart masking by the old mode from masking by the new one, and shows whether status bits leak into a wide-mode link word. Set mode is run with a zero and a nonzero link index, which separates the write suppression from the mode-bit splice into the old link contents. Call/return chains cover all four width pairings and feed the call's saved word back as the return target, so that a wrongly placed mode bit shows up as a wrong return mode. Idle cycles between requests show whether valid and write enable leak.

// File: rtl/blu_pkg.sv
package blu_pkg;

    parameter int unsigned WORD_W   = 32;
    parameter int unsigned NARROW_W = 24;
    parameter int unsigned IDX_W    = 4;
    parameter int unsigned ILC_W    = 2;
    parameter int unsigned CC_W     = 2;
    parameter int unsigned PM_W     = 4;

    localparam int unsigned WIDE_W   = WORD_W - 1;
    localparam int unsigned STATUS_W = ILC_W + CC_W + PM_W;
    localparam int unsigned MODE_BIT = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_LINK_LEGACY  = 2'd0,
        OP_SAVE         = 2'd1,
        OP_SAVE_SETMODE = 2'd2,
        OP_SETMODE      = 2'd3
    } blu_op_e;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } amode_e;

    typedef struct packed {
        word_t  target;
        amode_e mode;
    } branch_res_t;

    typedef struct packed {
        word_t             word;
        logic              wr;
        logic [IDX_W-1:0]  idx;
    } link_res_t;

    function automatic word_t mask_addr(input word_t a, input amode_e m);
        word_t r;
        r = '0;
        if (m == MODE_WIDE) begin
            r[WIDE_W-1:0] = a[WIDE_W-1:0];
        end else begin
            r[NARROW_W-1:0] = a[NARROW_W-1:0];
        end
        return r;
    endfunction

    function automatic logic sets_mode(input blu_op_e op);
        return (op == OP_SAVE_SETMODE) || (op == OP_SETMODE);
    endfunction

endpackage

// File: rtl/blu_branch_sel.sv
module blu_branch_sel
    import blu_pkg::*;
(
    input  blu_op_e     op,
    input  amode_e      cur_mode,
    input  word_t       target_word,
    output branch_res_t res
);
    amode_e new_mode;

    always_comb begin
        if (sets_mode(op)) begin
            new_mode = amode_e'(target_word[MODE_BIT]);
        end else begin
            new_mode = cur_mode;
        end
        res.mode   = new_mode;
        res.target = mask_addr(target_word, new_mode);
    end

endmodule

// File: rtl/blu_link_gen.sv
module blu_link_gen
    import blu_pkg::*;
(
    input  blu_op_e           op,
    input  amode_e            cur_mode,
    input  word_t             next_addr,
    input  word_t             link_val,
    input  logic [IDX_W-1:0]  link_idx,
    input  logic [ILC_W-1:0]  ilc,
    input  logic [CC_W-1:0]   cc,
    input  logic [PM_W-1:0]   pmask,
    output link_res_t         res
);
    word_t ret_masked;
    word_t wide_form;
    word_t status_form;

    always_comb begin
        ret_masked  = mask_addr(next_addr, cur_mode);
        wide_form   = ret_masked;
        wide_form[MODE_BIT] = 1'b1;
        status_form = '0;
        status_form[NARROW_W-1:0] = next_addr[NARROW_W-1:0];
        status_form[WORD_W-1 -: STATUS_W] = {ilc, cc, pmask};

        res.idx = link_idx;
        res.wr  = 1'b1;
        unique case (op)
            OP_LINK_LEGACY: begin
                res.word = (cur_mode == MODE_WIDE) ? wide_form : status_form;
            end
            OP_SAVE: begin
                res.word = (cur_mode == MODE_WIDE) ? wide_form : ret_masked;
            end
            OP_SAVE_SETMODE: begin
                res.word = ret_masked;
                res.word[MODE_BIT] = cur_mode;
            end
            default: begin
                res.word = link_val;
                res.word[MODE_BIT] = cur_mode;
                res.wr   = (link_idx != '0);
            end
        endcase
    end

endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
    import blu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_op,
    input  logic                 in_cur_mode,
    input  logic [WORD_W-1:0]    in_target,
    input  logic [WORD_W-1:0]    in_link_val,
    input  logic [IDX_W-1:0]     in_link_idx,
    input  logic [WORD_W-1:0]    in_next_addr,
    input  logic [ILC_W-1:0]     in_ilc,
    input  logic [CC_W-1:0]      in_cc,
    input  logic [PM_W-1:0]      in_pmask,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_target,
    output logic                 out_mode,
    output logic                 out_wr_en,
    output logic [IDX_W-1:0]     out_wr_idx,
    output logic [WORD_W-1:0]    out_link
);
    blu_op_e     op;
    amode_e      cur_mode;
    branch_res_t br;
    link_res_t   lk;

    assign op       = blu_op_e'(in_op);
    assign cur_mode = amode_e'(in_cur_mode);

    blu_branch_sel u_branch (
        .op          (op),
        .cur_mode    (cur_mode),
        .target_word (in_target),
        .res         (br)
    );

    blu_link_gen u_link (
        .op        (op),
        .cur_mode  (cur_mode),
        .next_addr (in_next_addr),
        .link_val  (in_link_val),
        .link_idx  (in_link_idx),
        .ilc       (in_ilc),
        .cc        (in_cc),
        .pmask     (in_pmask),
        .res       (lk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_target <= '0;
            out_mode   <= 1'b0;
            out_wr_en  <= 1'b0;
            out_wr_idx <= '0;
            out_link   <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr_en <= in_valid && lk.wr;
            if (in_valid) begin
                out_target <= br.target;
                out_mode   <= br.mode;
                out_wr_idx <= lk.idx;
                out_link   <= lk.word;
            end
        end
    end

    // R2: write enable only with a valid result
    a_r2_wr_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> out_valid);

    // R2: one-cycle latency of valid
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R3: narrow result never carries bits above 24
    a_r3_narrow_mask: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_mode) |-> (out_target[WORD_W-1:NARROW_W] == '0));

    // R3: wide result never carries the flag bit
    a_r3_wide_mask: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode) |-> !out_target[MODE_BIT]);

    // R4 R5: non-mode-setting operations keep the mode
    a_r4_r5_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op[1]) |=> (out_mode == $past(in_cur_mode)));

    // R6: call records caller mode, takes callee mode from target
    a_r6_mode_swap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2) |=>
            (out_mode == $past(in_target[MODE_BIT]) && out_link[MODE_BIT] == $past(in_cur_mode)));

    // R7: set mode with link index 0 writes nothing
    a_r7_no_link: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3 && in_link_idx == '0) |=> !out_wr_en);

    // R8: saving operations always write
    a_r8_save_writes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'd3) |=> out_wr_en);

endmodule

// File: tb/branch_link_unit_bench.sv
module branch_link_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic        in_cur_mode = 1'b0;
    logic [31:0] in_target = '0;
    logic [31:0] in_link_val = '0;
    logic [3:0]  in_link_idx = '0;
    logic [31:0] in_next_addr = '0;
    logic [1:0]  in_ilc = '0;
    logic [1:0]  in_cc = '0;
    logic [3:0]  in_pmask = '0;
    logic        out_valid;
    logic [31:0] out_target;
    logic        out_mode;
    logic        out_wr_en;
    logic [3:0]  out_wr_idx;
    logic [31:0] out_link;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // expected values from the model
    bit          e_valid;
    logic [31:0] e_target;
    bit          e_mode;
    bit          e_wr;
    logic [3:0]  e_idx;
    logic [31:0] e_link;

    always #4 clk = ~clk;

    branch_link_unit u_branch_link_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_cur_mode(in_cur_mode), .in_target(in_target),
        .in_link_val(in_link_val), .in_link_idx(in_link_idx),
        .in_next_addr(in_next_addr), .in_ilc(in_ilc), .in_cc(in_cc),
        .in_pmask(in_pmask), .out_valid(out_valid), .out_target(out_target),
        .out_mode(out_mode), .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx),
        .out_link(out_link)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model of one request
    task automatic model(input int op, input bit m, input logic [31:0] tgt,
                         input logic [31:0] lv, input logic [3:0] idx,
                         input logic [31:0] nxt, input logic [1:0] ilc,
                         input logic [1:0] cc, input logic [3:0] pm);
        bit nm;
        logic [31:0] ret;
        nm  = (op >= 2) ? tgt[31] : m;
        e_valid  = 1;
        e_mode   = nm;
        e_target = nm ? (tgt & 32'h7FFF_FFFF) : (tgt & 32'h00FF_FFFF);
        e_idx    = idx;
        e_wr     = 1;
        ret = m ? (nxt & 32'h7FFF_FFFF) : (nxt & 32'h00FF_FFFF);
        case (op)
            0: e_link = m ? (ret | 32'h8000_0000)
                          : ((32'(ilc) << 30) | (32'(cc) << 28) | (32'(pm) << 24) | ret);
            1: e_link = m ? (ret | 32'h8000_0000) : ret;
            2: e_link = ret | (32'(m) << 31);
            default: begin
                e_link = (lv & 32'h7FFF_FFFF) | (32'(m) << 31);
                e_wr   = (idx != 0);
            end
        endcase
    endtask

    task automatic compare(input string tag);
        chk(out_valid == e_valid, {tag, " R2 valid"}, 32'(out_valid), 32'(e_valid));
        chk(out_wr_en == (e_valid && e_wr), {tag, " R8 wr_en"}, 32'(out_wr_en), 32'(e_valid && e_wr));
        if (e_valid) begin
            chk(out_target == e_target, {tag, " R3 target"}, out_target, e_target);
            chk(out_mode == e_mode, {tag, " mode"}, 32'(out_mode), 32'(e_mode));
            chk(out_wr_idx == e_idx, {tag, " R8 idx"}, 32'(out_wr_idx), 32'(e_idx));
            if (e_wr)
                chk(out_link == e_link, {tag, " link"}, out_link, e_link);
        end
    endtask

    task automatic req(input string tag, input int op, input bit m, input logic [31:0] tgt,
                       input logic [31:0] lv, input logic [3:0] idx, input logic [31:0] nxt);
        @(negedge clk);
        in_valid = 1; in_op = 2'(op); in_cur_mode = m; in_target = tgt;
        in_link_val = lv; in_link_idx = idx; in_next_addr = nxt;
        in_ilc = 2'd2; in_cc = 2'd1; in_pmask = 4'hA;
        model(op, m, tgt, lv, idx, nxt, 2'd2, 2'd1, 4'hA);
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 0; in_op = 2'd3; in_link_idx = 4'd0;
        e_valid = 0;
        @(posedge clk); #1;
        compare(tag);
    endtask

    // R9 call/return round trip
    task automatic round_trip(input bit caller, input bit callee);
        logic [31:0] saved;
        logic [31:0] nxt;
        nxt = 32'hDE12_3456;
        req("R9 call", 2, caller, {callee, 31'h3BCD_EF01}, 32'h0, 4'd14, nxt);
        saved = out_link;
        req("R9 return", 3, callee, saved, 32'h0, 4'd0, 32'h0000_0100);
        chk(out_mode == caller, "R9 return mode", 32'(out_mode), 32'(caller));
        chk(out_target == (caller ? (nxt & 32'h7FFF_FFFF) : (nxt & 32'h00FF_FFFF)),
            "R9 return addr", out_target, caller ? (nxt & 32'h7FFF_FFFF) : (nxt & 32'h00FF_FFFF));
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 0 && out_wr_en == 0 && out_mode == 0 && out_wr_idx == 0,
            "R1 reset flags", {out_valid, out_wr_en, out_mode, out_wr_idx}, 32'h0);
        chk(out_target == 0 && out_link == 0, "R1 reset data", out_target ^ out_link, 32'h0);
        @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        chk(out_valid == 0 && out_target == 0 && out_link == 0, "R1 after reset",
            out_target | out_link | 32'(out_valid), 32'h0);

        // every operation, both starting modes, target flag set and clear
        for (int op = 0; op < 4; op++) begin
            for (int m = 0; m < 2; m++) begin
                for (int f = 0; f < 2; f++) begin
                    string tg;
                    tg = (op == 0) ? "R4" : (op == 1) ? "R5" : (op == 2) ? "R6" : "R7";
                    req(tg, op, m[0], {f[0], 31'h7E9A_5C3D}, 32'hF1F2_F3F4, 4'd14, 32'hF3C0_FFEE);
                end
            end
        end
        // set mode with no link register
        req("R7 idx0 narrow", 3, 0, 32'h8055_6677, 32'h1234_5678, 4'd0, 32'h0);
        req("R7 idx0 wide", 3, 1, 32'h0F55_6677, 32'h1234_5678, 4'd0, 32'h0);
        idle("R2 idle");
        req("R4 after idle", 0, 0, 32'hFFFF_FFFF, 32'h0, 4'd5, 32'hFFFF_FFFF);
        idle("R2 idle2");
        idle("R2 idle3");
        round_trip(0, 1);
        round_trip(1, 0);
        round_trip(0, 0);
        round_trip(1, 1);
        idle("R2 end");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule